// File: doc/BRIEF.md
# Memory and I/O Bus Decoder

This block sits between one bus master and a set of slaves and decides, every cycle, which slaves take part in the current transfer. The master's address lines serve two separate spaces. A qualifier input picks memory space or port space.

In memory space, each memory slave owns a half-open window given by a base and a size. It is selected when the address falls inside that window. It receives the address as an offset from its base. Write data is cut down to the data width configured for that region.

In port space, only the low 8 bits of the address count. Each port slave is selected when those bits equal its port number.

Selection and read-data steering are combinational. A read that no slave claims returns zero and raises a registered error pulse in the following cycle.

Slave slots are numbered with the memory regions first (slots 0 to N_MEM-1) and the port devices after them. When several slaves claim a read, the highest slot number supplies the data.

The default configuration has these slots:
- Slot 0: a 16-bit region at base 0x000, size 0x800.
- Slot 1: an 8-bit region at base 0x700, size 0x200. It overlaps slot 0 from 0x700 to 0x7FF.
- Slot 2: port 0xFE.
- Slot 3: port 0xFF.
- Slot 4: a second device on port 0xFE.

Top module: `bus_decoder`

## Requirements
- R1: While `m_io` is 1, only `m_addr[7:0]` takes part in port matching; the upper address bits are ignored, so address 0x3FE selects the port-0xFE slots (2 and 4).
- R2: With `m_io` 0 and a strobe (`m_rd` or `m_wr`) active, memory slot i is selected exactly when base_i <= `m_addr` < base_i + size_i. The lower bound is inclusive and the upper bound is exclusive.
- R3: A port slot is selected only while `m_io` is 1 and `m_addr[7:0]` equals its port number. No memory slot is ever selected while `m_io` is 1, even when the address lies inside its window.
- R4: With neither `m_rd` nor `m_wr` active, `s_sel` and `s_we` are all zero. On a write, `s_we` is asserted for every selected slot, not only one.
- R5: On a read claimed by several slots, `m_rdata` carries the `s_rdata` field of the highest-numbered selected slot. The field of slot i is `s_rdata[16*i +: 16]`.
- R6: A read with no selected slot gives `m_rdata` = 0 in the same cycle. `m_dec_err` is 1 in the next cycle and 0 again after a cycle without such a read. A write never raises `m_dec_err`.
- R7: The `s_wdata` field of a memory slot carries `m_wdata` masked to that region's data width: 16 bits for slot 0 and 8 bits for slot 1. Port slots receive all 16 bits.
- R8: The `s_offset` field of a selected memory slot is `m_addr` minus its base. That field is 0 when the slot is not selected. Port slots always carry offset 0.
- R9: After reset, `m_dec_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | 12 | Master address |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_io | input | 1 | Space qualifier: 1 = port space, 0 = memory space |
| m_wdata | input | 16 | Master write data |
| m_rdata | output | 16 | Read data steered back to the master |
| m_dec_err | output | 1 | Registered pulse after an unclaimed read |
| s_sel | output | 5 | Per-slot select |
| s_we | output | 5 | Per-slot write enable |
| s_offset | output | 60 | Per-slot address offset, 12 bits per slot |
| s_wdata | output | 80 | Per-slot write data, 16 bits per slot |
| s_rdata | input | 80 | Per-slot read data, 16 bits per slot |

## Verification
Selects, write enables, offsets, masked write data and the steered read data all follow the inputs in the same cycle. The bench therefore changes inputs on the falling edge and checks these outputs one nanosecond later, before any rising edge. `m_dec_err` comes out of one register, so it is checked at the falling edge after the rising edge that captured the unclaimed read. It is checked once more, one cycle later, after the read has been withdrawn, to confirm the pulse has ended. Window edges, overlapping claims and port matches with stray upper address bits are each set up so that the expected slot pattern differs from the one a faulty compare would give.

// File: rtl/bus_dec_pkg.sv
`timescale 1ns/1ps
package bus_dec_pkg;

    localparam int DEF_ADDR_W = 12;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_PORT_W = 8;

    typedef enum logic [0:0] {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    typedef struct packed {
        logic   rd;
        logic   wr;
        space_e space;
    } bus_cmd_t;

    // Mask of w low ones, saturating at 64 bits.
    function automatic logic [63:0] low_ones(input int w);
        if (w >= 64) return '1;
        return (64'(1) << w) - 64'(1);
    endfunction

    function automatic logic strobe_of(input bus_cmd_t c);
        return c.rd | c.wr;
    endfunction

endpackage

// File: rtl/mem_window_match.sv
`timescale 1ns/1ps
module mem_window_match
    import bus_dec_pkg::*;
#(
    parameter int               ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] BASE  = '0,
    parameter logic [ADDR_W:0]   SIZE  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_cmd_t          cmd,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W:0] LO = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI = LO + SIZE;

    logic [ADDR_W:0] addr_ext;
    logic            in_win;

    always_comb begin
        addr_ext = {1'b0, addr};
        in_win   = (addr_ext >= LO) && (addr_ext < HI);
        hit      = in_win && (cmd.space == SPACE_MEM) && strobe_of(cmd);
        offset   = hit ? (addr - BASE) : '0;
    end
endmodule

// File: rtl/port_match.sv
`timescale 1ns/1ps
module port_match
    import bus_dec_pkg::*;
#(
    parameter int               PORT_W = DEF_PORT_W,
    parameter logic [PORT_W-1:0] PORT  = '0
) (
    input  logic [PORT_W-1:0] port_addr,
    input  bus_cmd_t          cmd,
    output logic              hit
);
    always_comb begin
        hit = (port_addr == PORT) && (cmd.space == SPACE_IO) && strobe_of(cmd);
    end
endmodule

// File: rtl/rdata_steer.sv
`timescale 1ns/1ps
module rdata_steer #(
    parameter int N_SLV  = 5,
    parameter int DATA_W = 16
) (
    input  logic                    rd,
    input  logic [N_SLV-1:0]        claim,
    input  logic [N_SLV*DATA_W-1:0] slot_rdata,
    output logic [DATA_W-1:0]       rdata,
    output logic                    any_claim
);
    logic [DATA_W-1:0] pick;

    // Ascending scan: a later (higher) slot overwrites earlier ones.
    always_comb begin
        pick = '0;
        for (int i = 0; i < N_SLV; i++) begin
            if (claim[i]) pick = slot_rdata[i*DATA_W +: DATA_W];
        end
        any_claim = |claim;
        rdata     = rd ? pick : '0;
    end
endmodule

// File: rtl/decode_err_reg.sv
`timescale 1ns/1ps
module decode_err_reg (
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic any_claim,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= rd & ~any_claim;
    end
endmodule

// File: rtl/bus_decoder.sv
`timescale 1ns/1ps
module bus_decoder
    import bus_dec_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int PORT_W = DEF_PORT_W,
    parameter int N_MEM  = 2,
    parameter int N_IO   = 3,
    parameter logic [N_MEM*ADDR_W-1:0]     MEM_BASE = {12'h700, 12'h000},
    parameter logic [N_MEM*(ADDR_W+1)-1:0] MEM_SIZE = {13'h0200, 13'h0800},
    parameter logic [N_MEM*8-1:0]          MEM_DW   = {8'd8, 8'd16},
    parameter logic [N_IO*PORT_W-1:0]      PORT_NUM = {8'hFE, 8'hFF, 8'hFE},
    localparam int N_SLV = N_MEM + N_IO
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       m_addr,
    input  logic                    m_rd,
    input  logic                    m_wr,
    input  logic                    m_io,
    input  logic [DATA_W-1:0]       m_wdata,
    output logic [DATA_W-1:0]       m_rdata,
    output logic                    m_dec_err,
    output logic [N_SLV-1:0]        s_sel,
    output logic [N_SLV-1:0]        s_we,
    output logic [N_SLV*ADDR_W-1:0] s_offset,
    output logic [N_SLV*DATA_W-1:0] s_wdata,
    input  logic [N_SLV*DATA_W-1:0] s_rdata
);
    bus_cmd_t         cmd;
    logic [N_SLV-1:0] claim;
    logic             any_claim;

    always_comb begin
        cmd.rd    = m_rd;
        cmd.wr    = m_wr;
        cmd.space = m_io ? SPACE_IO : SPACE_MEM;
    end

    for (genvar m = 0; m < N_MEM; m++) begin : g_mem
        localparam logic [ADDR_W-1:0] BASE_M = MEM_BASE[m*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W:0]   SIZE_M = MEM_SIZE[m*(ADDR_W+1) +: ADDR_W+1];
        localparam int                DW_M   = int'(MEM_DW[m*8 +: 8]);
        localparam logic [DATA_W-1:0] WMASK  = DATA_W'(low_ones(DW_M));

        mem_window_match #(
            .ADDR_W (ADDR_W),
            .BASE   (BASE_M),
            .SIZE   (SIZE_M)
        ) u_win (
            .addr   (m_addr),
            .cmd    (cmd),
            .hit    (claim[m]),
            .offset (s_offset[m*ADDR_W +: ADDR_W])
        );

        assign s_wdata[m*DATA_W +: DATA_W] = m_wdata & WMASK;
    end

    for (genvar p = 0; p < N_IO; p++) begin : g_port
        localparam int S = N_MEM + p;

        port_match #(
            .PORT_W (PORT_W),
            .PORT   (PORT_NUM[p*PORT_W +: PORT_W])
        ) u_port (
            .port_addr (m_addr[PORT_W-1:0]),
            .cmd       (cmd),
            .hit       (claim[S])
        );

        assign s_offset[S*ADDR_W +: ADDR_W] = '0;
        assign s_wdata[S*DATA_W +: DATA_W]  = m_wdata;
    end

    assign s_sel = claim;
    assign s_we  = claim & {N_SLV{m_wr}};

    rdata_steer #(
        .N_SLV  (N_SLV),
        .DATA_W (DATA_W)
    ) u_steer (
        .rd         (m_rd),
        .claim      (claim),
        .slot_rdata (s_rdata),
        .rdata      (m_rdata),
        .any_claim  (any_claim)
    );

    decode_err_reg u_err (
        .clk       (clk),
        .rst       (rst),
        .rd        (m_rd),
        .any_claim (any_claim),
        .err       (m_dec_err)
    );
endmodule

// File: rtl/bus_decoder_chk.sv
`timescale 1ns/1ps
module bus_decoder_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int N_MEM  = 2,
    parameter int N_IO   = 3,
    parameter logic [N_MEM*8-1:0] MEM_DW = {8'd8, 8'd16},
    localparam int N_SLV = N_MEM + N_IO
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    m_rd,
    input logic                    m_wr,
    input logic                    m_io,
    input logic [DATA_W-1:0]       m_rdata,
    input logic                    m_dec_err,
    input logic [N_SLV-1:0]        s_sel,
    input logic [N_SLV-1:0]        s_we,
    input logic [N_SLV*ADDR_W-1:0] s_offset,
    input logic [N_SLV*DATA_W-1:0] s_wdata
);
    a_r3_no_mem_in_io: assert property (@(posedge clk) disable iff (rst)
        m_io |-> (s_sel[N_MEM-1:0] == '0));

    a_r4_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
        !(m_rd || m_wr) |-> (s_sel == '0 && s_we == '0));

    a_r4_we_all_claims: assert property (@(posedge clk) disable iff (rst)
        m_wr |-> (s_we == s_sel));

    a_r6_zero_on_miss: assert property (@(posedge clk) disable iff (rst)
        (m_rd && s_sel == '0) |-> (m_rdata == '0));

    a_r6_err_follows: assert property (@(posedge clk) disable iff (rst)
        (m_rd && s_sel == '0) |=> m_dec_err);

    a_r6_err_cause: assert property (@(posedge clk) disable iff (rst)
        m_dec_err |-> $past(m_rd && s_sel == '0));

    for (genvar m = 0; m < N_MEM; m++) begin : g_mchk
        localparam int DW = int'(MEM_DW[m*8 +: 8]);
        if (DW < DATA_W) begin : g_narrow
            a_r7_wdata_width: assert property (@(posedge clk) disable iff (rst)
                s_wdata[m*DATA_W + DW +: DATA_W - DW] == '0);
        end
        a_r8_offset_idle: assert property (@(posedge clk) disable iff (rst)
            !s_sel[m] |-> (s_offset[m*ADDR_W +: ADDR_W] == '0));
    end

    for (genvar p = N_MEM; p < N_SLV; p++) begin : g_pchk
        a_r8_port_offset: assert property (@(posedge clk) disable iff (rst)
            s_offset[p*ADDR_W +: ADDR_W] == '0);
    end
endmodule

bind bus_decoder bus_decoder_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_MEM  (N_MEM),
    .N_IO   (N_IO),
    .MEM_DW (MEM_DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .m_rd      (m_rd),
    .m_wr      (m_wr),
    .m_io      (m_io),
    .m_rdata   (m_rdata),
    .m_dec_err (m_dec_err),
    .s_sel     (s_sel),
    .s_we      (s_we),
    .s_offset  (s_offset),
    .s_wdata   (s_wdata)
);

// File: tb/test_bus_decoder.sv
`timescale 1ns/1ps
module test_bus_decoder;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] m_addr = '0;
    logic          m_rd = 1'b0, m_wr = 1'b0, m_io = 1'b0;
    logic [DW-1:0] m_wdata = '0;
    logic [DW-1:0] m_rdata;
    logic          m_dec_err;
    logic [NS-1:0] s_sel, s_we;
    logic [NS*AW-1:0] s_offset;
    logic [NS*DW-1:0] s_wdata;
    logic [NS*DW-1:0] s_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Each slot answers with its own constant: 0xA0A0 + slot.
    initial begin
        for (int i = 0; i < NS; i++) s_rdata[i*DW +: DW] = 16'hA0A0 + 16'(i);
    end

    bus_decoder i_bus_decoder (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
        .m_io(m_io), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_dec_err(m_dec_err), .s_sel(s_sel), .s_we(s_we),
        .s_offset(s_offset), .s_wdata(s_wdata), .s_rdata(s_rdata)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic drive(input logic io, input logic rd, input logic wr,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        m_io = io; m_rd = rd; m_wr = wr; m_addr = a; m_wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    function automatic logic [AW-1:0] off_of(input int s);
        return s_offset[s*AW +: AW];
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R9 dec_err after reset", 32'(m_dec_err), 0);
        check("R4 no select when idle", 32'(s_sel), 0);
    endtask

    task automatic t_mem_read();
        drive(1'b0, 1'b1, 1'b0, 12'h100, '0);
        check("R2 slot0 only at 0x100", 32'(s_sel), 32'b00001);
        check("R8 slot0 offset", 32'(off_of(0)), 32'h100);
        check("R8 slot1 offset idle", 32'(off_of(1)), 0);
        check("R5 single claimant data", 32'(m_rdata), 32'hA0A0);
        drive(1'b0, 1'b1, 1'b0, 12'h0FF, '0);
        check("R3 ports silent in memory space", 32'(s_sel), 32'b00001);
        idle();
    endtask

    task automatic t_overlap();
        drive(1'b0, 1'b1, 1'b0, 12'h7FF, '0);
        check("R2 overlap selects both", 32'(s_sel), 32'b00011);
        check("R5 highest slot wins", 32'(m_rdata), 32'hA0A1);
        check("R8 slot1 offset", 32'(off_of(1)), 32'h0FF);
        check("R8 slot0 offset", 32'(off_of(0)), 32'h7FF);
        idle();
    endtask

    task automatic t_edges();
        drive(1'b0, 1'b1, 1'b0, 12'h6FF, '0);
        check("R2 below slot1 base", 32'(s_sel), 32'b00001);
        drive(1'b0, 1'b1, 1'b0, 12'h700, '0);
        check("R2 slot1 base inclusive", 32'(s_sel), 32'b00011);
        drive(1'b0, 1'b1, 1'b0, 12'h800, '0);
        check("R2 slot0 end exclusive", 32'(s_sel), 32'b00010);
        drive(1'b0, 1'b1, 1'b0, 12'h8FF, '0);
        check("R2 slot1 last word", 32'(s_sel), 32'b00010);
        check("R8 slot1 last offset", 32'(off_of(1)), 32'h1FF);
        drive(1'b0, 1'b1, 1'b0, 12'h900, '0);
        check("R2 slot1 end exclusive", 32'(s_sel), 0);
        check("R6 unclaimed read data", 32'(m_rdata), 0);
        idle();
        check("R6 error pulse after miss", 32'(m_dec_err), 1);
        idle();
        check("R6 error pulse ends", 32'(m_dec_err), 0);
    endtask

    task automatic t_io_read();
        drive(1'b1, 1'b1, 1'b0, 12'h3FE, '0);
        check("R1 upper bits ignored in port space", 32'(s_sel), 32'b10100);
        check("R5 duplicate port, highest wins", 32'(m_rdata), 32'hA0A4);
        drive(1'b1, 1'b1, 1'b0, 12'h0FE, '0);
        check("R3 no memory slot in port space", 32'(s_sel[1:0]), 0);
        check("R8 port offset zero", 32'(off_of(4)), 0);
        drive(1'b1, 1'b1, 1'b0, 12'h010, '0);
        check("R3 unmatched port", 32'(s_sel), 0);
        check("R6 unmatched port data", 32'(m_rdata), 0);
        idle();
        check("R6 error after port miss", 32'(m_dec_err), 1);
        idle();
    endtask

    task automatic t_writes();
        drive(1'b0, 1'b0, 1'b1, 12'h7F0, 16'hABCD);
        check("R4 write enables all claimants", 32'(s_we), 32'b00011);
        check("R7 slot0 full width", 32'(s_wdata[0 +: DW]), 32'hABCD);
        check("R7 slot1 masked to 8 bits", 32'(s_wdata[DW +: DW]), 32'h00CD);
        drive(1'b1, 1'b0, 1'b1, 12'h0FF, 16'h1234);
        check("R4 port write enable", 32'(s_we), 32'b01000);
        check("R7 port full width", 32'(s_wdata[3*DW +: DW]), 32'h1234);
        drive(1'b0, 1'b0, 1'b1, 12'hA00, 16'h5555);
        check("R4 unclaimed write selects none", 32'(s_we), 0);
        idle();
        check("R6 write miss raises no error", 32'(m_dec_err), 0);
        drive(1'b0, 1'b0, 1'b0, 12'h100, 16'h5555);
        check("R4 no strobe no select", 32'(s_sel), 0);
        check("R4 no strobe no write enable", 32'(s_we), 0);
    endtask

    initial begin
        t_reset();
        t_mem_read();
        t_overlap();
        t_edges();
        t_io_read();
        t_writes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule